// File: doc/BRIEF.md
# Successive-Approximation Register Controller

This block is the digital half of a successive-approximation converter. An external DAC turns the block's trial code into a voltage, and an external comparator reports whether that voltage is above the sampled input. A conversion starts when the active-low write request is seen while the block is idle. The block then runs a binary search. Starting at the most significant bit, each clock raises one bit, looks at the comparator, and either keeps or drops that bit. The final code is the largest value whose DAC level does not exceed the input, so the result is truncated downward.

While the search runs, a busy flag is high and the previous result stays in a separate output register. When the last bit is decided, the search value is copied into that output register, busy falls and the end-of-conversion flag rises. A host reads the output register through an active-low chip select and an active-low read strobe. When both are low, the data lines are driven. Otherwise they float, and a drive-enable output tells a pad ring or bus fabric when the lines are driven.

Top module: `sar_ctrl`

## Requirements
- R1: After a synchronous reset, busy and end-of-conversion are low, the output register holds zero, and the data lines are not driven while chip select is high.
- R2: When wr_n is sampled low at a rising edge while busy is low, then after that edge busy is 1, end-of-conversion is 0, and the trial code has only its most significant bit set.
- R3: During a conversion, the trial code in the k-th busy cycle (k counted from 0) holds the bits already decided above position WIDTH-1-k, a 1 at that position, and zeros below it.
- R4: At each busy edge the bit under test is cleared if cmp_high is 1, meaning the DAC level is above the input. It is kept if cmp_high is 0.
- R5: Busy stays high for exactly WIDTH rising edges after the start edge. On the last of them, busy falls and end-of-conversion rises.
- R6: The stored result is the largest code c for which c times the step size does not exceed the input. With a 10 mV step, an input of 505 mV gives 0011_0010, and an input above full scale gives all ones.
- R7: A low wr_n sampled while busy is high is ignored. The running search and its length are unchanged.
- R8: End-of-conversion stays high until the next accepted start, which clears it.
- R9: The output register changes only at the edge where end-of-conversion rises. A read during a conversion returns the previous result.
- R10: data_oe is 1 exactly when cs_n and rd_n are both 0. Then data_bus carries the output register; otherwise data_bus is high impedance.
- R11: Busy and end-of-conversion are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low conversion request |
| cmp_high | input | 1 | Comparator: 1 when the DAC level from trial_code is above the input |
| cs_n | input | 1 | Active-low chip select for the read port |
| rd_n | input | 1 | Active-low read strobe |
| trial_code | output | WIDTH | Code presented to the DAC |
| busy | output | 1 | High while a conversion runs |
| eoc | output | 1 | End of conversion, high from completion until the next start |
| data_oe | output | 1 | High when data_bus is driven |
| data_bus | output | WIDTH | Output register when read, high impedance otherwise |

## Verification
The comparator is modelled as the trial code times a 10 mV step compared against an input given in millivolts. The search is tried with random inputs spread over the range, and with directed inputs at zero, one step below and exactly on a code boundary, at 505 mV, at full scale and above it. Boundary inputs separate a correct downward truncation from rounding, and from an off-by-one at the least significant bit. Some conversions get a second write request and a host read in their middle. These show whether a restart is ignored and whether the previous result stays readable. Each busy cycle's trial code is compared with the bench's own search, which pins down the bit order and the keep-or-drop rule separately from the final value.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_bit_decide.sv
// Combinational decision for the bit under test, plus the next trial code.
module sar_bit_decide #(
  parameter int W = 8
) (
  input  logic [W-1:0] trial,
  input  logic [W-1:0] mask,
  input  logic         cmp_high,
  output logic [W-1:0] kept,
  output logic [W-1:0] next_trial,
  output logic         last_bit
);
  logic [W-1:0] lower_mask;

  // Drop the bit under test when the DAC level overshoots the input.
  for (genvar i = 0; i < W; i++) begin : g_keep
    assign kept[i] = trial[i] & ~(mask[i] & cmp_high);
  end

  assign lower_mask = mask >> 1;
  assign next_trial = kept | lower_mask;
  assign last_bit   = mask[0];
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_req,
  input  logic         cmp_high,
  output logic [W-1:0] trial_code,
  output logic         busy,
  output logic         eoc,
  output logic         load_result,
  output logic [W-1:0] result_next
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  sar_state_e   state_q;
  logic [W-1:0] trial_q;
  logic [W-1:0] mask_q;
  logic         eoc_q;
  logic [W-1:0] kept;
  logic [W-1:0] next_trial;
  logic         last_bit;

  sar_bit_decide #(.W(W)) u_decide (
    .trial      (trial_q),
    .mask       (mask_q),
    .cmp_high   (cmp_high),
    .kept       (kept),
    .next_trial (next_trial),
    .last_bit   (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      trial_q <= '0;
      mask_q  <= '0;
      eoc_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            // Clear the search value and set the top bit for its first trial.
            state_q <= ST_CONV;
            trial_q <= TOP_BIT;
            mask_q  <= TOP_BIT;
            eoc_q   <= 1'b0;
          end
        end
        ST_CONV: begin
          if (last_bit) begin
            state_q <= ST_IDLE;
            trial_q <= kept;
            mask_q  <= '0;
            eoc_q   <= 1'b1;
          end else begin
            trial_q <= next_trial;
            mask_q  <= mask_q >> 1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trial_code  = trial_q;
  assign busy        = (state_q == ST_CONV);
  assign eoc         = eoc_q;
  assign load_result = (state_q == ST_CONV) && last_bit;
  assign result_next = kept;
endmodule

// File: rtl/sar_result_port.sv
module sar_result_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_value,
  input  logic         cs_n,
  input  logic         rd_n,
  output logic [W-1:0] result_q,
  output logic         data_oe,
  output logic [W-1:0] data_bus
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (load) begin
      result_q <= load_value;
    end
  end

  assign data_oe  = ~cs_n & ~rd_n;
  assign data_bus = data_oe ? result_q : {W{1'bz}};
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             cmp_high,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy,
  output logic             eoc,
  output logic             data_oe,
  output logic [WIDTH-1:0] data_bus
);
  logic             load_result;
  logic [WIDTH-1:0] result_next;
  logic [WIDTH-1:0] result_q;
  logic             start_req;

  // Requests arriving mid-conversion are dropped by the sequencer's idle-only accept.
  assign start_req = ~wr_n;

  sar_sequencer #(.W(WIDTH)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .cmp_high    (cmp_high),
    .trial_code  (trial_code),
    .busy        (busy),
    .eoc         (eoc),
    .load_result (load_result),
    .result_next (result_next)
  );

  sar_result_port #(.W(WIDTH)) u_port (
    .clk        (clk),
    .rst        (rst),
    .load       (load_result),
    .load_value (result_next),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .result_q   (result_q),
    .data_oe    (data_oe),
    .data_bus   (data_bus)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_n,
  input logic         busy,
  input logic         eoc,
  input logic [W-1:0] trial_code,
  input logic [W-1:0] result_q
);
  localparam int CW = $clog2(W + 1) + 1;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_n) |=> (busy && !eoc && trial_code == TOP_BIT));

  // A restart accepted mid-search would stretch this count (R7 as well).
  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == CW'(W)));

  p_eoc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (eoc && wr_n) |=> eoc);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> $rose(eoc));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(busy && eoc));
endmodule

bind sar_ctrl sar_ctrl_chk #(.W(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_n       (wr_n),
  .busy       (busy),
  .eoc        (eoc),
  .trial_code (trial_code),
  .result_q   (result_q)
);

// File: tb/tb_sar_ctrl.sv
`timescale 1ns/1ps
module tb_sar_ctrl;
  localparam int W       = 8;
  localparam int STEP_MV = 10;
  localparam int MAXC    = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_n = 1'b1;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic         cmp_high;
  logic [W-1:0] trial_code;
  logic         busy, eoc, data_oe;
  wire  [W-1:0] data_bus;

  int vin_mv = 0;
  int checks = 0;
  int errors = 0;
  int last_res = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Comparator model: DAC level above the input.
  always_comb cmp_high = (int'(trial_code) * STEP_MV) > vin_mv;

  sar_ctrl #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .cmp_high(cmp_high),
    .cs_n(cs_n), .rd_n(rd_n), .trial_code(trial_code),
    .busy(busy), .eoc(eoc), .data_oe(data_oe), .data_bus(data_bus)
  );

  function automatic int model_code(int v);
    int c = v / STEP_MV;
    return (c > MAXC) ? MAXC : c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_check(string req, int exp);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(data_oe === 1'b1 && int'(data_bus) == exp, req, int'(data_bus), exp);
    cs_n = 1'b1; rd_n = 1'b1;
    #1;
  endtask

  task automatic convert(int vin, bit poke);
    logic [W-1:0] exp_t;
    int res;
    vin_mv = vin;
    @(negedge clk); wr_n = 1'b0;
    @(posedge clk);
    exp_t = {1'b1, {(W-1){1'b0}}};
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      wr_n = 1'b1;
      if (i == 0) chk(busy && !eoc, "R2", {busy, eoc}, 2);
      chk(busy && !eoc, "R11", {busy, eoc}, 2);
      chk(trial_code == exp_t, "R3", int'(trial_code), int'(exp_t));
      if (poke && i == 2) wr_n = 1'b0;           // R7: request while busy
      if (poke && i == 3) read_check("R9", last_res);
      // R4: reference search step
      if (int'(exp_t) * STEP_MV > vin) exp_t[W-1-i] = 1'b0;
      if (i < W - 1) exp_t[W-2-i] = 1'b1;
    end
    @(negedge clk);
    chk(!busy && eoc, "R5", {busy, eoc}, 1);
    res = model_code(vin);
    chk(int'(exp_t) == res, "R4", int'(exp_t), res);
    read_check("R6", res);
    last_res = res;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk(!busy && !eoc, "R1", {busy, eoc}, 0);
    chk(!data_oe, "R1", data_oe, 0);
    read_check("R1", 0);

    // Directed corner cases, R6
    convert(505, 1'b0);
    convert(0, 1'b0);
    convert(9, 1'b0);
    convert(10, 1'b0);
    convert(2550, 1'b0);
    convert(9999, 1'b1);
    convert(1279, 1'b1);
    convert(1280, 1'b0);

    // R8: eoc holds while idle
    repeat (3) @(negedge clk);
    chk(eoc && !busy, "R8", {busy, eoc}, 1);
    // R10: partial selects leave bus undriven
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(!data_oe, "R10", data_oe, 0);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(!data_oe, "R10", data_oe, 0);
    cs_n = 1'b1; rd_n = 1'b1; #1;
    read_check("R10", last_res);

    // Random inputs, some with mid-conversion poke
    for (int n = 0; n < 40; n++) begin
      convert(int'($urandom_range(2700, 0)), n[0]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule